// File: doc/BRIEF.md
# Fetched Word Lane Replicator

This block sits behind the memory read port of a display fetch engine. Every fetch for a bitplane or sprite channel reads a full 32-bit word from the aligned address, with pointer bits 1:0 cleared. Depending on the channel's fetch width and on where the pointer really pointed, only one 16-bit half of that word may carry valid data. The block picks the valid half, copies it into both halves of the presented word, and also produces a 16-bit word for the narrow legacy display path.

Each channel has its own 2-bit fetch-mode field, one for bitplanes and one for sprites. The same replication rule applies to both fields. A channel-type input chooses which field counts for the current read. When pointer bit 1 is set, the low half is chosen. Otherwise, if bit 1 of the active mode field is set, the high half is chosen and duplicated. In all other cases the word passes through unchanged. A legacy flag forces duplication of the chosen half. The result is registered, so it appears one cycle after a valid read, and it holds its value while no read is valid.

Top module: `wordLaneReplicator`

## Requirements
- R1: While reset is asserted and after its release, before any valid read, outValid, outWord and outHalf are all zero.
- R2: outValid is high in the cycle after a cycle with inValid high, and low in the cycle after a cycle with inValid low.
- R3: With ptrBit1 = 1 and legacyMode = 0, outWord is rawWord[15:0] in both halves, whatever the mode fields hold.
- R4: For a bitplane read (isSprite = 0) with ptrBit1 = 0, legacyMode = 0 and bplMode bit 1 = 1, outWord is rawWord[31:16] in both halves.
- R5: With ptrBit1 = 0, legacyMode = 0 and bit 1 of the active mode field = 0, outWord equals rawWord unchanged. Bit 0 of either mode field has no effect.
- R6: A sprite read (isSprite = 1) obeys the same rule as R4 and R5, but uses sprMode and ignores bplMode. A bitplane read ignores sprMode.
- R7: outHalf is rawWord[15:0] when ptrBit1 = 1 and rawWord[31:16] when ptrBit1 = 0, whatever the mode and legacy inputs hold.
- R8: With legacyMode = 1, outWord is outHalf in both halves, whatever the mode fields hold.
- R9: In the cycle after a cycle with inValid low, outWord and outHalf keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The read data on rawWord is valid this cycle |
| rawWord | input | 32 | Word read from the 32-bit aligned address |
| ptrBit1 | input | 1 | Bit 1 of the channel pointer |
| bplMode | input | 2 | Fetch-mode field for bitplane channels |
| sprMode | input | 2 | Fetch-mode field for sprite channels |
| isSprite | input | 1 | 1 for a sprite channel read, 0 for a bitplane read |
| legacyMode | input | 1 | Narrow legacy path: always duplicate the chosen half |
| outValid | output | 1 | The registered outputs were loaded from a valid read |
| outWord | output | 32 | Presented 32-bit data word |
| outHalf | output | 16 | Selected 16-bit word for the legacy path |

## Verification
The bench sweeps every combination of pointer bit, both mode fields, channel type and legacy flag over three data words whose halves all differ. Any swapped, duplicated or passed-through lane is therefore visible in the output. Because the mode field that is not selected also runs through all four values, the sweep shows whether the wrong field is being read, and whether bit 0 leaks into the decision. Idle cycles with changed data between reads show whether the outputs hold their values, and whether the valid strobe follows the input one cycle later.

// File: rtl/laneDupPkg.sv
package laneDupPkg;
  typedef struct packed {
    logic loadEn;     // capture a new result this cycle
    logic pickLow;    // choose the low half as the valid half
    logic replicate;  // copy the chosen half into both halves
  } laneStrobes_t;
endpackage

// File: rtl/laneDupCtrl.sv
module laneDupCtrl
  import laneDupPkg::*;
#(
  parameter int MODE_W  = 2,
  parameter int DUP_BIT = 1
) (
  input  logic              inValid,
  input  logic              ptrBit1,
  input  logic [MODE_W-1:0] bplMode,
  input  logic [MODE_W-1:0] sprMode,
  input  logic              isSprite,
  input  logic              legacyMode,
  output laneStrobes_t      strobes
);
  logic [MODE_W-1:0] activeMode;

  always_comb begin
    activeMode        = isSprite ? sprMode : bplMode;
    strobes.loadEn    = inValid;
    strobes.pickLow   = ptrBit1;
    // An unaligned pointer, a wide mode that fetches one half, or the narrow
    // legacy path all leave one valid half to be duplicated.
    strobes.replicate = ptrBit1 | activeMode[DUP_BIT] | legacyMode;
  end
endmodule

// File: rtl/laneDupData.sv
module laneDupData
  import laneDupPkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  laneStrobes_t        strobes,
  input  logic [2*HALF_W-1:0] rawWord,
  output logic                outValid,
  output logic [2*HALF_W-1:0] outWord,
  output logic [HALF_W-1:0]   outHalf
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] lowHalf;
  logic [HALF_W-1:0] highHalf;
  logic [HALF_W-1:0] chosenHalf;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    lowHalf    = rawWord[HALF_W-1:0];
    highHalf   = rawWord[WORD_W-1:HALF_W];
    chosenHalf = strobes.pickLow ? lowHalf : highHalf;
    nextWord   = strobes.replicate ? {chosenHalf, chosenHalf} : rawWord;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outHalf  <= '0;
    end else begin
      outValid <= strobes.loadEn;
      if (strobes.loadEn) begin
        outWord <= nextWord;
        outHalf <= chosenHalf;
      end
    end
  end
endmodule

// File: rtl/wordLaneReplicator.sv
module wordLaneReplicator
  import laneDupPkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int MODE_W  = 2,
  parameter int DUP_BIT = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [2*HALF_W-1:0] rawWord,
  input  logic                ptrBit1,
  input  logic [MODE_W-1:0]   bplMode,
  input  logic [MODE_W-1:0]   sprMode,
  input  logic                isSprite,
  input  logic                legacyMode,
  output logic                outValid,
  output logic [2*HALF_W-1:0] outWord,
  output logic [HALF_W-1:0]   outHalf
);
  laneStrobes_t strobes;

  laneDupCtrl #(.MODE_W(MODE_W), .DUP_BIT(DUP_BIT)) ctrl_i (
    .inValid(inValid), .ptrBit1(ptrBit1), .bplMode(bplMode),
    .sprMode(sprMode), .isSprite(isSprite), .legacyMode(legacyMode),
    .strobes(strobes)
  );

  laneDupData #(.HALF_W(HALF_W)) data_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rawWord(rawWord),
    .outValid(outValid), .outWord(outWord), .outHalf(outHalf)
  );
endmodule

// File: rtl/wordLaneReplicatorChk.sv
module wordLaneReplicatorChk #(
  parameter int HALF_W  = 16,
  parameter int MODE_W  = 2,
  parameter int DUP_BIT = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic [2*HALF_W-1:0] rawWord,
  input logic                ptrBit1,
  input logic [MODE_W-1:0]   bplMode,
  input logic [MODE_W-1:0]   sprMode,
  input logic                isSprite,
  input logic                legacyMode,
  input logic                outValid,
  input logic [2*HALF_W-1:0] outWord,
  input logic [HALF_W-1:0]   outHalf
);
  localparam int WORD_W = 2 * HALF_W;

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  // R3
  low_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && ptrBit1 && !legacyMode) |=>
      (outWord == {2{$past(rawWord[HALF_W-1:0])}}));
  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !ptrBit1 && !legacyMode && !isSprite && !bplMode[DUP_BIT]) |=>
      (outWord == $past(rawWord)));
  // R6
  spr_high_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !ptrBit1 && !legacyMode && isSprite && sprMode[DUP_BIT]) |=>
      (outWord == {2{$past(rawWord[WORD_W-1:HALF_W])}}));
  // R7
  half_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outHalf == ($past(ptrBit1) ? $past(rawWord[HALF_W-1:0])
                                            : $past(rawWord[WORD_W-1:HALF_W]))));
  // R8
  legacy_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && legacyMode) |=> (outWord == {outHalf, outHalf}));
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(outWord) && $stable(outHalf)));
endmodule

bind wordLaneReplicator wordLaneReplicatorChk #(
  .HALF_W(HALF_W), .MODE_W(MODE_W), .DUP_BIT(DUP_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .rawWord(rawWord),
  .ptrBit1(ptrBit1), .bplMode(bplMode), .sprMode(sprMode),
  .isSprite(isSprite), .legacyMode(legacyMode), .outValid(outValid),
  .outWord(outWord), .outHalf(outHalf)
);

// File: tb/wordLaneReplicator_tb_top.sv
module wordLaneReplicator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] rawWord = '0;
  logic        ptrBit1 = 1'b0;
  logic [1:0]  bplMode = '0;
  logic [1:0]  sprMode = '0;
  logic        isSprite = 1'b0;
  logic        legacyMode = 1'b0;
  logic        outValid;
  logic [31:0] outWord;
  logic [15:0] outHalf;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordLaneReplicator dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .rawWord(rawWord),
    .ptrBit1(ptrBit1), .bplMode(bplMode), .sprMode(sprMode),
    .isSprite(isSprite), .legacyMode(legacyMode), .outValid(outValid),
    .outWord(outWord), .outHalf(outHalf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dataPattern(input int idx);
    case (idx)
      0:       return 32'h1234_ABCD;
      1:       return 32'hF00F_0FF0;
      default: return 32'h8001_7FFE;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] expWord;
    logic [15:0] expHalf;
    string       tag;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid", {31'd0, outValid}, 32'd0);
    check("R1 word", outWord, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release, no read yet
    check("R1 half", {16'd0, outHalf}, 32'd0);
    check("R1 valid idle", {31'd0, outValid}, 32'd0);

    for (int p = 0; p < 2; p++)
      for (int leg = 0; leg < 2; leg++)
        for (int spr = 0; spr < 2; spr++)
          for (int bm = 0; bm < 4; bm++)
            for (int sm = 0; sm < 4; sm++)
              for (int d = 0; d < 3; d++) begin
                logic [1:0] mode;
                inValid    = 1'b1;
                rawWord    = dataPattern(d);
                ptrBit1    = p[0];
                legacyMode = leg[0];
                isSprite   = spr[0];
                bplMode    = bm[1:0];
                sprMode    = sm[1:0];
                mode       = spr[0] ? sm[1:0] : bm[1:0];
                expHalf    = p[0] ? rawWord[15:0] : rawWord[31:16];
                if (leg[0]) begin
                  expWord = {expHalf, expHalf}; tag = "R8";
                end else if (p[0]) begin
                  expWord = {expHalf, expHalf}; tag = "R3";
                end else if (mode[1]) begin
                  expWord = {expHalf, expHalf}; tag = spr[0] ? "R6" : "R4";
                end else begin
                  expWord = rawWord; tag = spr[0] ? "R6" : "R5";
                end
                @(negedge clk);
                check("R2 valid high", {31'd0, outValid}, 32'd1);
                check("R7 half", {16'd0, outHalf}, {16'd0, expHalf});
                check(tag, outWord, expWord);
                if (d == 2) begin
                  // idle cycle with changed inputs: outputs must hold
                  inValid  = 1'b0;
                  rawWord  = ~rawWord;
                  ptrBit1  = ~ptrBit1;
                  @(negedge clk);
                  check("R2 valid low", {31'd0, outValid}, 32'd0);
                  check("R9 word hold", outWord, expWord);
                  check("R9 half hold", {16'd0, outHalf}, {16'd0, expHalf});
                end
              end

    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end
endmodule